// File: doc/BRIEF.md
# Tick Counter with Compare Interrupt

This block keeps a free-running cycle counter and a compare register beside it. When the running count reaches the programmed compare value, and the compare interrupt is not disabled, the block latches a timer-match flag in a 16-bit soft-interrupt word. That word stays set until software removes it. Any set bit in the word raises the `irq` output.

Software reaches the block through a single-cycle write port and a combinational read port. Both ports use a 3-bit register select. Each of the two 64-bit words carries a control bit in its most significant position. In the counter word, bit 63 is a non-privileged-trap flag. The count itself does not touch this flag. In the compare word, bit 63 is an interrupt-disable bit. The soft-interrupt word can be written directly, or changed through a set alias that ORs ones in and a clear alias that removes ones.

Top module: `tick_cmp_timer`

## Requirements
- R1: Synchronous reset sets the count to 0, the non-privileged-trap flag (counter word bit 63) to 1, the compare value to 0, interrupt-disable (compare word bit 63) to 1 and the soft-interrupt word to 0. `irq` is 0.
- R2: When the counter is not being written, the count in bits [62:0] grows by one on every clock edge and bit 63 holds its value.
- R3: The count wraps from all ones to 0 modulo 2^63 and leaves bit 63 unchanged.
- R4: A write with select 0 loads wr_data[62:0] into the count and wr_data[63] into the flag. In that cycle the write takes priority over the increment, and counting resumes from the loaded value on the next edge.
- R5: A write with select 1 loads the compare value from wr_data[62:0] and interrupt-disable from wr_data[63]. Reading select 1 returns both.
- R6: Suppose interrupt-disable is 0 and the count becomes equal to the compare value. Then soft-interrupt bit 0 (timer match) is set on the following clock edge and stays set while no write clears it.
- R7: While interrupt-disable is 1, an equal count leaves soft-interrupt bit 0 unchanged.
- R8: A write with select 3 (set alias) ORs wr_data[15:0] into the soft-interrupt word.
- R9: A write with select 4 (clear alias) clears every soft-interrupt bit that is 1 in wr_data[15:0] and leaves the others unchanged. A match in the same cycle still sets bit 0.
- R10: A write with select 2 replaces the soft-interrupt word with wr_data[15:0]. The word's layout is: bit 0 timer match, bits [14:1] interrupt level, bit 15 second timer match. Reads of select 2 return zeros in bits [63:16].
- R11: `irq` is 1 exactly when some bit of the soft-interrupt word is 1.
- R12: The read port returns the counter word for select 0, the compare word for select 1 and the soft-interrupt word for select 2. It returns all zeros for every other select, including the write-only aliases 3 and 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_sel | input | 3 | Write target: 0 counter, 1 compare, 2 soft word, 3 set alias, 4 clear alias |
| wr_data | input | 64 | Write data |
| rd_sel | input | 3 | Read target: 0 counter, 1 compare, 2 soft word |
| rd_data | output | 64 | Read data, combinational |
| irq | output | 1 | High while any soft-interrupt bit is set |

## Verification
A counter that skips or repeats a value shows up on the very next counter read. The same fault also moves the match one or more cycles away from the edge predicted by arithmetic on the loaded count and compare value. For that reason, the bench checks that `irq` is still low on the cycle the count equals the compare value and high exactly one edge later. If the match detector or the disable gating holds a wrong state, `irq` either fails to rise or rises while interrupt-disable is set, and the bench sees this within one cycle of the equal count. Errors in the alias merge logic show up on the soft-word read taken right after each write.

// File: rtl/tick_pkg.sv
package tick_pkg;

    localparam int SOFT_W = 16;
    localparam int LVL_W  = 14;

    typedef enum logic [2:0] {
        SEL_CNT   = 3'd0,
        SEL_CMP   = 3'd1,
        SEL_SOFT  = 3'd2,
        SEL_SET   = 3'd3,
        SEL_CLR   = 3'd4
    } tick_sel_e;

    typedef struct packed {
        logic              tm_hi;
        logic [LVL_W-1:0]  level;
        logic              tm;
    } soft_word_t;

    typedef struct packed {
        logic dir;
        logic set;
        logic clr;
    } soft_op_t;

    function automatic soft_word_t soft_merge(input soft_word_t cur,
                                              input soft_op_t   op,
                                              input soft_word_t bits,
                                              input logic       hit);
        soft_word_t nxt;
        nxt = cur;
        if (op.dir)      nxt = bits;
        else if (op.set) nxt = cur | bits;
        else if (op.clr) nxt = cur & ~bits;
        nxt.tm = nxt.tm | hit;
        return nxt;
    endfunction

endpackage

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int CNT_W = 63
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             ld_flag,
    output logic [CNT_W-1:0] cnt_q,
    output logic             flag_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            flag_q <= 1'b1;
        end else if (ld) begin
            cnt_q  <= ld_val;
            flag_q <= ld_flag;
        end else begin
            cnt_q  <= cnt_q + ONE;
        end
    end
endmodule

// File: rtl/tick_compare.sv
module tick_compare #(
    parameter int CNT_W = 63
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             ld_dis,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] cmp_q,
    output logic             dis_q,
    output logic             hit_o
);
    logic eq;
    logic eq_prev;

    assign eq    = (cnt_i == cmp_q);
    assign hit_o = eq & ~eq_prev & ~dis_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q   <= '0;
            dis_q   <= 1'b1;
            eq_prev <= 1'b1;
        end else begin
            eq_prev <= eq;
            if (ld) begin
                cmp_q <= ld_val;
                dis_q <= ld_dis;
            end
        end
    end
endmodule

// File: rtl/tick_softint.sv
module tick_softint
    import tick_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  soft_op_t   op,
    input  soft_word_t bits,
    input  logic       hit,
    output soft_word_t soft_q
);
    always_ff @(posedge clk) begin
        if (rst) soft_q <= '0;
        else     soft_q <= soft_merge(soft_q, op, bits, hit);
    end
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
    import tick_pkg::*;
#(
    parameter int CNT_W = 63
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [CNT_W:0]    wr_data,
    input  logic [2:0]        rd_sel,
    output logic [CNT_W:0]    rd_data,
    output logic              irq
);
    localparam int WORD_W = CNT_W + 1;

    tick_sel_e  wsel;
    tick_sel_e  rsel;
    logic       ld_cnt;
    logic       ld_cmp;
    soft_op_t   sop;
    soft_word_t sbits;

    logic [CNT_W-1:0] cnt_val;
    logic             cnt_flag;
    logic [CNT_W-1:0] cmp_val;
    logic             cmp_dis;
    logic             hit;
    soft_word_t       soft_w;
    logic [SOFT_W-1:0] soft_bits;

    assign wsel   = tick_sel_e'(wr_sel);
    assign rsel   = tick_sel_e'(rd_sel);
    assign ld_cnt = wr_en && (wsel == SEL_CNT);
    assign ld_cmp = wr_en && (wsel == SEL_CMP);
    assign sop.dir = wr_en && (wsel == SEL_SOFT);
    assign sop.set = wr_en && (wsel == SEL_SET);
    assign sop.clr = wr_en && (wsel == SEL_CLR);
    assign sbits   = soft_word_t'(wr_data[SOFT_W-1:0]);

    tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .ld      (ld_cnt),
        .ld_val  (wr_data[CNT_W-1:0]),
        .ld_flag (wr_data[CNT_W]),
        .cnt_q   (cnt_val),
        .flag_q  (cnt_flag)
    );

    tick_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk    (clk),
        .rst    (rst),
        .ld     (ld_cmp),
        .ld_val (wr_data[CNT_W-1:0]),
        .ld_dis (wr_data[CNT_W]),
        .cnt_i  (cnt_val),
        .cmp_q  (cmp_val),
        .dis_q  (cmp_dis),
        .hit_o  (hit)
    );

    tick_softint u_soft (
        .clk    (clk),
        .rst    (rst),
        .op     (sop),
        .bits   (sbits),
        .hit    (hit),
        .soft_q (soft_w)
    );

    assign soft_bits = soft_w;
    assign irq       = |soft_bits;

    always_comb begin
        case (rsel)
            SEL_CNT:  rd_data = {cnt_flag, cnt_val};
            SEL_CMP:  rd_data = {cmp_dis, cmp_val};
            SEL_SOFT: rd_data = WORD_W'(soft_bits);
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tick_cmp_timer_chk.sv
module tick_cmp_timer_chk #(
    parameter int CNT_W = 63
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [2:0]       wr_sel,
    input logic [CNT_W:0]   wr_data,
    input logic             irq,
    input logic [CNT_W-1:0] cnt_val,
    input logic             cnt_flag,
    input logic [CNT_W-1:0] cmp_val,
    input logic             cmp_dis,
    input logic [15:0]      soft_bits
);
    logic wcnt, wsoft, wset, eqn;
    assign wcnt  = wr_en && (wr_sel == 3'd0);
    assign wsoft = wr_en && (wr_sel inside {3'd2, 3'd3, 3'd4});
    assign wset  = wr_en && (wr_sel == 3'd3);
    assign eqn   = (cnt_val == cmp_val);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !wcnt |=> cnt_val == CNT_W'($past(cnt_val) + CNT_W'(1))); // R2

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wcnt |=> $stable(cnt_flag)); // R3

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
        wcnt |=> cnt_val == $past(wr_data[CNT_W-1:0])); // R4

    AST_MATCH_SET: assert property (@(posedge clk) disable iff (rst)
        (eqn && !cmp_dis && !$past(eqn)) |=> soft_bits[0]); // R6

    AST_DIS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cmp_dis && !soft_bits[0] && !wsoft) |=> !soft_bits[0]); // R7

    AST_SET_OR: assert property (@(posedge clk) disable iff (rst)
        wset |=> (soft_bits & $past(wr_data[15:0])) == $past(wr_data[15:0])); // R8
endmodule

bind tick_cmp_timer tick_cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .irq       (irq),
    .cnt_val   (cnt_val),
    .cnt_flag  (cnt_flag),
    .cmp_val   (cmp_val),
    .cmp_dis   (cmp_dis),
    .soft_bits (soft_bits)
);

// File: tb/tick_cmp_timer_bench.sv
module tick_cmp_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd0;
    logic [63:0] wr_data = '0;
    logic [2:0]  rd_sel = 3'd0;
    logic [63:0] rd_data;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    localparam logic [63:0] TOP = 64'h8000_0000_0000_0000;

    always #2.5 clk = ~clk;

    tick_cmp_timer u_tick_cmp_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [63:0] v);
        rd_sel = sel;
        #0.5;
        v = rd_data;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        rd(3'd0, v); check("R1 count", v, TOP);
        rd(3'd1, v); check("R1 compare", v, TOP);
        rd(3'd2, v); check("R1 soft", v, 64'd0);
        check("R1 irq", {63'd0, irq}, 64'd0);
        step(3);
        rd(3'd0, v); check("R2 count after 3", v, TOP | 64'd3);
    endtask

    task automatic t_load_wrap();
        logic [63:0] v;
        wr(3'd0, 64'h7FFF_FFFF_FFFF_FFFE);
        rd(3'd0, v); check("R4 load", v, 64'h7FFF_FFFF_FFFF_FFFE);
        step(1);
        rd(3'd0, v); check("R3 max", v, 64'h7FFF_FFFF_FFFF_FFFF);
        step(1);
        rd(3'd0, v); check("R3 wrap", v, 64'd0);
        wr(3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        step(1);
        rd(3'd0, v); check("R3 wrap flag kept", v, TOP);
        wr(3'd0, 64'd1000);
        step(4);
        rd(3'd0, v); check("R4 resume", v, 64'd1004);
    endtask

    task automatic t_match();
        logic [63:0] v;
        wr(3'd1, 64'd100);
        rd(3'd1, v); check("R5 compare readback", v, 64'd100);
        wr(3'd0, 64'd90);
        step(10);
        rd(3'd0, v); check("R2 count at equal", v, 64'd100);
        check("R6 not yet", {63'd0, irq}, 64'd0);
        step(1);
        check("R6 irq", {63'd0, irq}, 64'd1);
        rd(3'd2, v); check("R6 soft bit0", v, 64'd1);
        step(5);
        rd(3'd2, v); check("R6 sticky", v, 64'd1);
        wr(3'd4, 64'd1);
        check("R9 cleared irq", {63'd0, irq}, 64'd0);
    endtask

    task automatic t_disabled();
        logic [63:0] v;
        wr(3'd1, TOP | 64'd200);
        rd(3'd1, v); check("R5 disable readback", v, TOP | 64'd200);
        wr(3'd0, 64'd190);
        step(20);
        check("R7 no irq", {63'd0, irq}, 64'd0);
        rd(3'd2, v); check("R7 soft", v, 64'd0);
    endtask

    task automatic t_soft();
        logic [63:0] v;
        wr(3'd3, 64'h8002);
        rd(3'd2, v); check("R8 set", v, 64'h8002);
        check("R11 irq", {63'd0, irq}, 64'd1);
        wr(3'd3, 64'h0010);
        rd(3'd2, v); check("R8 or", v, 64'h8012);
        wr(3'd4, 64'h8000);
        rd(3'd2, v); check("R9 clear", v, 64'h0012);
        wr(3'd2, 64'hFFFF_0000_0000_4001);
        rd(3'd2, v); check("R10 direct", v, 64'h4001);
        wr(3'd4, 64'hFFFF);
        rd(3'd2, v); check("R9 clear all", v, 64'd0);
        check("R11 irq low", {63'd0, irq}, 64'd0);
    endtask

    task automatic t_rdsel();
        logic [63:0] v;
        wr(3'd3, 64'h0004);
        rd(3'd3, v); check("R12 sel3", v, 64'd0);
        rd(3'd4, v); check("R12 sel4", v, 64'd0);
        rd(3'd5, v); check("R12 sel5", v, 64'd0);
        rd(3'd7, v); check("R12 sel7", v, 64'd0);
        rd(3'd2, v); check("R12 sel2", v, 64'h0004);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load_wrap();
        t_match();
        t_disabled();
        t_soft();
        t_rdsel();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule